// File: doc/BRIEF.md
# Output Voltage Target Selector

This block decides which VID code and which signed offset a voltage regulator should aim for. Two control paths can request changes. The first is a serial voltage-ID command path, reduced here to a one-cycle strobe with a command code and an 8-bit argument. The second is a register-write path with an address, data and a write strobe. Each register write gets exactly one ACK or NACK in the following cycle. Which path owns the target and the offset is set by a 2-bit ownership field. That field is written like any other register, but the block only uses a new value when the enable input rises.

At start-up in the serial-owned modes, the target is loaded from a 4-bit boot code that maps to a fixed VID code. The boot code has to agree with the 5 mV / 10 mV step setting. A write that pairs a boot code with the wrong step is refused. The block presents the raw VID target, the offset, the step flag and the active upper limit. It also gives the effective target: VID plus offset, saturated between zero and that limit. Values that would normally come from non-volatile storage are parameters applied at reset.

Top module: `vout_target_sel`

## Requirements
- R1: The ownership field is written at register address 0, bits [1:0], and that write is always ACKed. The active mode takes the stored field only in the cycle after `en` rises. A write while enabled does not change the active mode.
- R2: In mode 00, serial commands own both the target and the offset. A register write to address 1 (target) is ACKed and has no effect. A register write to address 2 (offset) is NACKed.
- R3: While `en` is low, the serial offset is held at zero, so in mode 00 the offset output reads zero one cycle after `en` falls.
- R4: In mode 01, serial commands own the target. A register offset write is ACKed and stored, but the offset output only takes it at the next rising `en`. Serial offset commands (code 2) have no effect.
- R5: In modes 10 and 11, register writes to address 1 (target, data[7:0]) and address 2 (offset, data[7:0] two's complement) show on the outputs one cycle later. Serial set-VID (code 0), set-work-point (code 1) and offset (code 2) commands have no effect. The upper limit is 0x17E.
- R6: A serial set-VID or set-work-point command changes the target only when the mode is 00 or 01, `en` is high and `ramp_done` is high.
- R7: When `en` rises into mode 00 or 01, the target is loaded from the boot VID for the stored boot code. Codes 1..12 map to 0.75, 0.80, 0.85, 0.90, 0.95, 1.00, 1.05, 1.10, 1.20, 1.25, 1.35 and 1.50 V at 5 mV per code. Codes 13..15 map to 1.60, 1.70 and 1.80 V at 10 mV per code. Code 0 maps to VID 0.
- R8: The boot setting is written at address 3, with the code in data[3:0] and the step in data[4] (1 = 10 mV). Codes 0..12 need step 0 and codes 13..15 need step 1. A write with a mismatched pair is NACKed and changes nothing. An accepted write updates the step output and the serial boot VID.
- R9: The effective target is VID + offset, clamped to 0 below and to the active limit above. In modes 00 and 01, the limit is the last serial max command (code 3, data[7:0]).
- R10: Every register write gets exactly one of ACK or NACK in the next cycle, and none without a write. Writes to addresses 4..7 are NACKed.
- R11: After reset the block is in mode 00 with boot code 6 (VID 0x97, 5 mV), target 0x97, offset 0 and limit 0xFF, and it drives no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Conversion enable; its rising edge latches the mode and starts up |
| ramp_done | input | 1 | Start-up ramp has finished |
| rw_valid | input | 1 | Register write strobe |
| rw_addr | input | 3 | Register address |
| rw_data | input | 8 | Register write data |
| rw_ack | output | 1 | Write accepted (one cycle after the strobe) |
| rw_nack | output | 1 | Write refused (one cycle after the strobe) |
| sv_valid | input | 1 | Serial command strobe |
| sv_cmd | input | 2 | 0 set VID, 1 set work point, 2 offset, 3 max VID |
| sv_data | input | 8 | Serial command argument |
| vid_target | output | 8 | Selected VID code |
| vid_offset | output | 8 | Selected offset, two's complement |
| step_10mv | output | 1 | 1 when the step is 10 mV per code |
| max_limit | output | 9 | Active upper limit |
| eff_target | output | 9 | VID + offset, saturated |

## Verification
The assertions assume that `rst` is held for at least one clock edge before any check, and that reset values for the boot code and step agree, as R8 requires. They also assume that no register write and no serial command falls in the same cycle as a rising `en`, because the decode in that cycle uses the old mode. The stimulus drives inputs only just after falling edges. Every enable toggle is kept as a standalone low cycle followed by a high cycle, with no strobe in either cycle. The outputs are compared against a behavioural model on every falling edge.

// File: rtl/vts_pkg.sv
package vts_pkg;
    parameter int VID_W  = 8;
    parameter int OFS_W  = 8;
    parameter int LIM_W  = VID_W + 1;
    parameter int ADDR_W = 3;
    parameter int DATA_W = 8;
    parameter int BOOT_W = 4;

    localparam logic [LIM_W-1:0]  REG_MODE_LIMIT = LIM_W'(382);
    localparam logic [BOOT_W-1:0] FIRST_WIDE_CODE = BOOT_W'(13);

    localparam logic [ADDR_W-1:0] ADR_MODE   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADR_TARGET = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ADR_OFFSET = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] ADR_BOOT   = ADDR_W'(3);

    typedef enum logic [1:0] {
        MODE_SV_ONLY = 2'b00,
        MODE_SPLIT   = 2'b01,
        MODE_REG_A   = 2'b10,
        MODE_REG_B   = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        SV_SETVID = 2'd0,
        SV_SETWP  = 2'd1,
        SV_SETOFS = 2'd2,
        SV_SETMAX = 2'd3
    } sv_cmd_e;

    typedef struct packed {
        logic [VID_W-1:0]        vid;
        logic signed [OFS_W-1:0] ofs;
        logic [LIM_W-1:0]        lim;
    } tgt_sel_t;

    function automatic logic is_reg_mode(input logic [1:0] m);
        return m[1];
    endfunction

    function automatic logic boot_needs_wide(input logic [BOOT_W-1:0] code);
        return code >= FIRST_WIDE_CODE;
    endfunction

    function automatic logic [VID_W-1:0] boot_to_vid(input logic [BOOT_W-1:0] code);
        logic [VID_W-1:0] v;
        case (code)
            4'd0:    v = 8'h00;
            4'd1:    v = 8'h65;
            4'd2:    v = 8'h6F;
            4'd3:    v = 8'h79;
            4'd4:    v = 8'h83;
            4'd5:    v = 8'h8D;
            4'd6:    v = 8'h97;
            4'd7:    v = 8'hA1;
            4'd8:    v = 8'hAB;
            4'd9:    v = 8'hBF;
            4'd10:   v = 8'hC9;
            4'd11:   v = 8'hDD;
            4'd12:   v = 8'hFB;
            4'd13:   v = 8'h6F;
            4'd14:   v = 8'h79;
            default: v = 8'h83;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/vts_mode_latch.sv
module vts_mode_latch
    import vts_pkg::*;
#(
    parameter logic [1:0] RST_MODE = 2'b00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [1:0] mode_cfg,
    output logic [1:0] act_mode,
    output logic       en_rise
);
    logic en_q;

    assign en_rise = en & ~en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            act_mode <= RST_MODE;
        end else begin
            en_q <= en;
            if (en_rise) act_mode <= mode_cfg;
        end
    end

    // R1
    mode_only_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_mode) |-> $past(en_rise));
endmodule

// File: rtl/vts_reg_path.sv
module vts_reg_path
    import vts_pkg::*;
#(
    parameter logic [1:0]        RST_MODE   = 2'b00,
    parameter logic [BOOT_W-1:0] RST_BOOT   = 4'd6,
    parameter logic [VID_W-1:0]  RST_TARGET = 8'h97
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [1:0]               act_mode,
    input  logic                     en_rise,
    input  logic                     rw_valid,
    input  logic [ADDR_W-1:0]        rw_addr,
    input  logic [DATA_W-1:0]        rw_data,
    output logic                     rw_ack,
    output logic                     rw_nack,
    output logic [1:0]               mode_cfg,
    output logic [VID_W-1:0]         reg_target,
    output logic signed [OFS_W-1:0]  reg_ofs_live,
    output logic signed [OFS_W-1:0]  reg_ofs_start,
    output logic                     step_wide,
    output logic                     boot_load,
    output logic [VID_W-1:0]         boot_load_vid
);
    logic              accept, reject;
    logic              wr_mode, wr_tgt, wr_ofs;
    logic [BOOT_W-1:0] new_code;
    logic              new_step, boot_ok;
    logic [BOOT_W-1:0] boot_q;

    assign new_code      = rw_data[BOOT_W-1:0];
    assign new_step      = rw_data[BOOT_W];
    assign boot_ok       = boot_needs_wide(new_code) == new_step;
    assign boot_load_vid = boot_to_vid(new_code);

    always_comb begin
        accept    = 1'b0;
        reject    = 1'b0;
        wr_mode   = 1'b0;
        wr_tgt    = 1'b0;
        wr_ofs    = 1'b0;
        boot_load = 1'b0;
        if (rw_valid) begin
            case (rw_addr)
                ADR_MODE: begin
                    accept  = 1'b1;
                    wr_mode = 1'b1;
                end
                ADR_TARGET: begin
                    accept = 1'b1;
                    wr_tgt = is_reg_mode(act_mode);
                end
                ADR_OFFSET: begin
                    if (act_mode == MODE_SV_ONLY) begin
                        reject = 1'b1;
                    end else begin
                        accept = 1'b1;
                        wr_ofs = 1'b1;
                    end
                end
                ADR_BOOT: begin
                    if (boot_ok) begin
                        accept    = 1'b1;
                        boot_load = 1'b1;
                    end else begin
                        reject = 1'b1;
                    end
                end
                default: reject = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rw_ack        <= 1'b0;
            rw_nack       <= 1'b0;
            mode_cfg      <= RST_MODE;
            reg_target    <= RST_TARGET;
            reg_ofs_live  <= '0;
            reg_ofs_start <= '0;
            boot_q        <= RST_BOOT;
            step_wide     <= boot_needs_wide(RST_BOOT);
        end else begin
            rw_ack  <= accept;
            rw_nack <= reject;
            if (wr_mode) mode_cfg <= rw_data[1:0];
            if (wr_tgt) reg_target <= rw_data[VID_W-1:0];
            if (wr_ofs) reg_ofs_live <= $signed(rw_data[OFS_W-1:0]);
            if (en_rise) reg_ofs_start <= reg_ofs_live;
            if (boot_load) begin
                boot_q    <= new_code;
                step_wide <= new_step;
            end
        end
    end

    // R10
    one_response_chk: assert property (@(posedge clk) disable iff (rst)
        rw_valid |=> (rw_ack ^ rw_nack));
    // R10
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
        !rw_valid |=> !(rw_ack || rw_nack));
    // R8
    boot_step_agree_chk: assert property (@(posedge clk) disable iff (rst)
        step_wide == boot_needs_wide(boot_q));
    // R4
    start_ofs_held_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(reg_ofs_start) |-> $past(en_rise));
endmodule

// File: rtl/vts_serial_path.sv
module vts_serial_path
    import vts_pkg::*;
#(
    parameter logic [BOOT_W-1:0] RST_BOOT = 4'd6,
    parameter logic [VID_W-1:0]  RST_VMAX = 8'hFF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    en_rise,
    input  logic                    ramp_done,
    input  logic [1:0]              act_mode,
    input  logic                    sv_valid,
    input  logic [1:0]              sv_cmd,
    input  logic [VID_W-1:0]        sv_data,
    input  logic                    boot_load,
    input  logic [VID_W-1:0]        boot_load_vid,
    output logic [VID_W-1:0]        sv_vid,
    output logic signed [OFS_W-1:0] sv_ofs,
    output logic [VID_W-1:0]        sv_max
);
    sv_cmd_e          cmd;
    logic             take_vid, take_ofs;
    logic [VID_W-1:0] sv_boot_vid;

    assign cmd      = sv_cmd_e'(sv_cmd);
    assign take_vid = sv_valid && (cmd == SV_SETVID || cmd == SV_SETWP)
                      && !is_reg_mode(act_mode) && en && ramp_done;
    assign take_ofs = sv_valid && cmd == SV_SETOFS && act_mode == MODE_SV_ONLY && en;

    always_ff @(posedge clk) begin
        if (rst) begin
            sv_boot_vid <= boot_to_vid(RST_BOOT);
            sv_vid      <= boot_to_vid(RST_BOOT);
            sv_ofs      <= '0;
            sv_max      <= RST_VMAX;
        end else begin
            if (boot_load) sv_boot_vid <= boot_load_vid;
            if (en_rise) sv_vid <= sv_boot_vid;
            else if (take_vid) sv_vid <= sv_data;
            if (!en) sv_ofs <= '0;
            else if (take_ofs) sv_ofs <= $signed(sv_data[OFS_W-1:0]);
            if (sv_valid && cmd == SV_SETMAX) sv_max <= sv_data;
        end
    end

    // R3
    ofs_zero_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (sv_ofs == '0));
    // R5
    reg_mode_sv_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (is_reg_mode(act_mode) && !en_rise) |=> $stable(sv_vid));
    // R6
    no_vid_before_ramp_chk: assert property (@(posedge clk) disable iff (rst)
        (!ramp_done && !en_rise) |=> $stable(sv_vid));
endmodule

// File: rtl/vts_target_calc.sv
module vts_target_calc
    import vts_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [1:0]              act_mode,
    input  logic [VID_W-1:0]        reg_target,
    input  logic signed [OFS_W-1:0] reg_ofs_live,
    input  logic signed [OFS_W-1:0] reg_ofs_start,
    input  logic [VID_W-1:0]        sv_vid,
    input  logic signed [OFS_W-1:0] sv_ofs,
    input  logic [VID_W-1:0]        sv_max,
    output tgt_sel_t                sel,
    output logic [LIM_W-1:0]        eff
);
    localparam int SUM_W = LIM_W + 2;

    logic signed [SUM_W-1:0] sum, lim_s;

    always_comb begin
        case (act_mode)
            MODE_SV_ONLY: sel = '{vid: sv_vid, ofs: sv_ofs,
                                  lim: {1'b0, sv_max}};
            MODE_SPLIT:   sel = '{vid: sv_vid, ofs: reg_ofs_start,
                                  lim: {1'b0, sv_max}};
            default:      sel = '{vid: reg_target, ofs: reg_ofs_live,
                                  lim: REG_MODE_LIMIT};
        endcase
    end

    assign sum   = $signed({{(SUM_W-VID_W){1'b0}}, sel.vid}) + SUM_W'(sel.ofs);
    assign lim_s = $signed({2'b00, sel.lim});

    always_comb begin
        if (sum < 0)          eff = '0;
        else if (sum > lim_s) eff = sel.lim;
        else                  eff = sum[LIM_W-1:0];
    end

    // R9
    eff_within_limit_chk: assert property (@(posedge clk) disable iff (rst)
        eff <= sel.lim);
    // R5
    reg_mode_limit_chk: assert property (@(posedge clk) disable iff (rst)
        is_reg_mode(act_mode) |-> (sel.lim == REG_MODE_LIMIT));
endmodule

// File: rtl/vout_target_sel.sv
module vout_target_sel
    import vts_pkg::*;
#(
    parameter logic [1:0]        RST_MODE   = 2'b00,
    parameter logic [BOOT_W-1:0] RST_BOOT   = 4'd6,
    parameter logic [VID_W-1:0]  RST_TARGET = 8'h97,
    parameter logic [VID_W-1:0]  RST_VMAX   = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              ramp_done,
    input  logic              rw_valid,
    input  logic [ADDR_W-1:0] rw_addr,
    input  logic [DATA_W-1:0] rw_data,
    output logic              rw_ack,
    output logic              rw_nack,
    input  logic              sv_valid,
    input  logic [1:0]        sv_cmd,
    input  logic [VID_W-1:0]  sv_data,
    output logic [VID_W-1:0]  vid_target,
    output logic [OFS_W-1:0]  vid_offset,
    output logic              step_10mv,
    output logic [LIM_W-1:0]  max_limit,
    output logic [LIM_W-1:0]  eff_target
);
    logic [1:0]              mode_cfg, act_mode;
    logic                    en_rise, boot_load;
    logic [VID_W-1:0]        boot_load_vid, reg_target, sv_vid, sv_max;
    logic signed [OFS_W-1:0] reg_ofs_live, reg_ofs_start, sv_ofs;
    tgt_sel_t                sel;

    vts_mode_latch #(.RST_MODE(RST_MODE)) u_mode (
        .clk(clk), .rst(rst), .en(en), .mode_cfg(mode_cfg),
        .act_mode(act_mode), .en_rise(en_rise)
    );

    vts_reg_path #(.RST_MODE(RST_MODE), .RST_BOOT(RST_BOOT), .RST_TARGET(RST_TARGET)) u_reg (
        .clk(clk), .rst(rst), .act_mode(act_mode), .en_rise(en_rise),
        .rw_valid(rw_valid), .rw_addr(rw_addr), .rw_data(rw_data),
        .rw_ack(rw_ack), .rw_nack(rw_nack), .mode_cfg(mode_cfg),
        .reg_target(reg_target), .reg_ofs_live(reg_ofs_live),
        .reg_ofs_start(reg_ofs_start), .step_wide(step_10mv),
        .boot_load(boot_load), .boot_load_vid(boot_load_vid)
    );

    vts_serial_path #(.RST_BOOT(RST_BOOT), .RST_VMAX(RST_VMAX)) u_sv (
        .clk(clk), .rst(rst), .en(en), .en_rise(en_rise), .ramp_done(ramp_done),
        .act_mode(act_mode), .sv_valid(sv_valid), .sv_cmd(sv_cmd), .sv_data(sv_data),
        .boot_load(boot_load), .boot_load_vid(boot_load_vid),
        .sv_vid(sv_vid), .sv_ofs(sv_ofs), .sv_max(sv_max)
    );

    vts_target_calc u_calc (
        .clk(clk), .rst(rst), .act_mode(act_mode), .reg_target(reg_target),
        .reg_ofs_live(reg_ofs_live), .reg_ofs_start(reg_ofs_start),
        .sv_vid(sv_vid), .sv_ofs(sv_ofs), .sv_max(sv_max),
        .sel(sel), .eff(eff_target)
    );

    assign vid_target = sel.vid;
    assign vid_offset = sel.ofs;
    assign max_limit  = sel.lim;
endmodule

// File: tb/tb_vout_target_sel.sv
`timescale 1ns/1ps
module tb_vout_target_sel;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0, ramp_done = 1'b0;
    logic       rw_valid = 1'b0, sv_valid = 1'b0;
    logic [2:0] rw_addr = '0;
    logic [7:0] rw_data = '0, sv_data = '0;
    logic [1:0] sv_cmd = '0;
    logic       rw_ack, rw_nack, step_10mv;
    logic [7:0] vid_target, vid_offset;
    logic [8:0] max_limit, eff_target;

    int n_chk = 0, n_fail = 0;
    bit done = 0, model_live = 0;

    always #2 clk = ~clk;

    vout_target_sel dut (
        .clk(clk), .rst(rst), .en(en), .ramp_done(ramp_done),
        .rw_valid(rw_valid), .rw_addr(rw_addr), .rw_data(rw_data),
        .rw_ack(rw_ack), .rw_nack(rw_nack),
        .sv_valid(sv_valid), .sv_cmd(sv_cmd), .sv_data(sv_data),
        .vid_target(vid_target), .vid_offset(vid_offset), .step_10mv(step_10mv),
        .max_limit(max_limit), .eff_target(eff_target)
    );

    // Behavioural reference state
    int m_cfg, m_act, m_enq, m_tgt, m_ofs_w, m_ofs_a, m_sv_vid, m_sv_ofs, m_sv_max;
    int m_boot, m_step, m_sv_boot, m_ack, m_nack;

    function automatic int boot_vid(int code);
        int mv[16] = '{0, 750, 800, 850, 900, 950, 1000, 1050, 1100, 1200,
                       1250, 1350, 1500, 1600, 1700, 1800};
        if (mv[code] == 0) return 0;
        if (code >= 13) return (mv[code] - 500) / 10 + 1;
        return (mv[code] - 250) / 5 + 1;
    endfunction

    function automatic int s8(int v);
        return (v >= 128) ? v - 256 : v;
    endfunction

    always @(posedge clk) begin
        model_live = 1;
        if (rst) begin
            m_cfg = 0; m_act = 0; m_enq = 0; m_tgt = 'h97; m_ofs_w = 0; m_ofs_a = 0;
            m_boot = 6; m_step = 0; m_sv_boot = boot_vid(6); m_sv_vid = m_sv_boot;
            m_sv_ofs = 0; m_sv_max = 255; m_ack = 0; m_nack = 0;
        end else begin
            int old_cfg, old_boot;
            bit rise;
            old_cfg = m_cfg; old_boot = m_sv_boot;
            rise = en && !m_enq;
            m_ack = 0; m_nack = 0;
            if (rw_valid) begin
                case (rw_addr)
                    0: begin m_ack = 1; m_cfg = rw_data[1:0]; end
                    1: begin m_ack = 1; if (m_act >= 2) m_tgt = rw_data; end
                    2: if (m_act == 0) m_nack = 1;
                       else begin m_ack = 1; m_ofs_w = s8(rw_data); end
                    3: if ((rw_data[3:0] >= 13) == rw_data[4]) begin
                           m_ack = 1; m_boot = rw_data[3:0]; m_step = rw_data[4];
                           m_sv_boot = boot_vid(rw_data[3:0]);
                       end else m_nack = 1;
                    default: m_nack = 1;
                endcase
            end
            if (sv_valid) begin
                if (sv_cmd <= 1 && m_act < 2 && en && ramp_done) m_sv_vid = sv_data;
                if (sv_cmd == 2 && m_act == 0 && en) m_sv_ofs = s8(sv_data);
                if (sv_cmd == 3) m_sv_max = sv_data;
            end
            if (!en) m_sv_ofs = 0;
            if (rise) begin
                m_ofs_a  = m_ofs_w;
                m_sv_vid = old_boot;
                m_act    = old_cfg;
            end
            m_enq = en;
        end
    end

    function automatic int exp_vid();  return (m_act >= 2) ? m_tgt : m_sv_vid; endfunction
    function automatic int exp_ofs();
        return (m_act >= 2) ? m_ofs_w : (m_act == 1) ? m_ofs_a : m_sv_ofs;
    endfunction
    function automatic int exp_max();  return (m_act >= 2) ? 382 : m_sv_max; endfunction
    function automatic int exp_eff();
        int s = exp_vid() + exp_ofs();
        if (s < 0) return 0;
        if (s > exp_max()) return exp_max();
        return s;
    endfunction

    task automatic chk(string req, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (model_live && !done) begin
            chk("R10 ack", rw_ack, m_ack);
            chk("R10 nack", rw_nack, m_nack);
            chk("R7 vid", vid_target, exp_vid());
            chk("R4 offset", $signed(vid_offset), exp_ofs());
            chk("R8 step", step_10mv, m_step);
            chk("R5 limit", max_limit, exp_max());
            chk("R9 eff", eff_target, exp_eff());
        end
    end

    task automatic rwr(int a, int d);
        rw_valid = 1; rw_addr = 3'(a); rw_data = 8'(d);
        @(negedge clk);
        rw_valid = 0;
    endtask

    task automatic svc(int c, int d);
        sv_valid = 1; sv_cmd = 2'(c); sv_data = 8'(d);
        @(negedge clk);
        sv_valid = 0;
    endtask

    task automatic toggle_en();
        en = 0; @(negedge clk);
        en = 1; @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got hang expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11 reset state
        chk("R11 vid", vid_target, 'h97);
        chk("R11 limit", max_limit, 'hFF);
        chk("R11 resp", {rw_ack, rw_nack}, 0);
        // Mode 00
        en = 1; @(negedge clk);
        svc(0, 'h40);
        chk("R6 no vid before ramp", vid_target, 'h97);
        ramp_done = 1;
        svc(1, 'h40);
        chk("R2 serial target", vid_target, 'h40);
        svc(2, 'hFD);
        chk("R9 vid+ofs", eff_target, 'h3D);
        rwr(1, 'h20);
        chk("R2 target ack", rw_ack, 1);
        chk("R2 target ignored", vid_target, 'h40);
        rwr(2, 5);
        chk("R2 offset nack", rw_nack, 1);
        svc(3, 'h30);
        chk("R9 clamp high", eff_target, 'h30);
        svc(3, 'hFF);
        svc(0, 'h02);
        svc(2, 'hF0);
        chk("R9 clamp low", eff_target, 0);
        en = 0; @(negedge clk);
        chk("R3 offset zero", vid_offset, 0);
        // Boot/step agreement
        rwr(3, 'h0D);
        chk("R8 mismatch nack", rw_nack, 1);
        chk("R8 step kept", step_10mv, 0);
        rwr(3, 'h1D);
        chk("R8 match ack", rw_ack, 1);
        chk("R8 step set", step_10mv, 1);
        en = 1; @(negedge clk);
        chk("R7 boot 1.60V", vid_target, 'h6F);
        // Mode 01
        rwr(0, 1);
        toggle_en();
        rwr(2, 4);
        chk("R4 offset held", vid_offset, 0);
        svc(2, 9);
        chk("R4 serial offset ignored", vid_offset, 0);
        svc(0, 'h50);
        chk("R4 serial target", vid_target, 'h50);
        toggle_en();
        chk("R4 offset applied", vid_offset, 4);
        chk("R7 boot reload", vid_target, 'h6F);
        // Mode write while enabled
        rwr(0, 2);
        chk("R1 mode ack", rw_ack, 1);
        chk("R1 mode not yet", max_limit, 'hFF);
        toggle_en();
        chk("R5 reg limit", max_limit, 'h17E);
        chk("R5 reg target", vid_target, 'h97);
        rwr(1, 'hF0);
        chk("R5 target immediate", vid_target, 'hF0);
        rwr(2, 'h7F);
        chk("R5 offset immediate", eff_target, 'h16F);
        rwr(1, 'hFF);
        chk("R9 top of limit", eff_target, 'h17E);
        svc(0, 'h10);
        svc(1, 'h11);
        chk("R5 setvid ignored", vid_target, 'hFF);
        svc(2, 1);
        chk("R5 serial offset ignored", vid_offset, 'h7F);
        rwr(2, 'h80);
        rwr(1, 'h05);
        chk("R9 negative clamp", eff_target, 0);
        // Mode 11
        rwr(0, 3);
        toggle_en();
        chk("R5 mode 11 limit", max_limit, 'h17E);
        rwr(5, 0);
        chk("R10 bad addr nack", rw_nack, 1);
        rwr(3, 'h02);
        chk("R8 boot 0.80 ack", rw_ack, 1);
        rwr(3, 'h1C);
        chk("R8 code12 wide nack", rw_nack, 1);
        rwr(0, 0);
        toggle_en();
        chk("R7 boot 0.80V", vid_target, 'h6F);
        chk("R8 step back", step_10mv, 0);
        chk("R3 offset after start", vid_offset, 0);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule